// File: doc/BRIEF.md
# Memory Error Statistics Collector

This block sits behind a memory ECC checker and turns its error reports into statistics. Each report is a single-cycle pulse. It carries a severity bit (correctable or uncorrectable), a bit saying whether the failing location is known, and a row index and a channel index. The block keeps several sets of saturating counters:

- controller-wide totals;
- counts for reports that arrive without a location;
- per-row counts;
- per-row, per-channel counts.

Next to the counters runs a whole-seconds timer, so software can turn counts into rates.

One clear command zeroes every counter and restarts the timer together. Two log enables gate a registered log-record output and nothing else, so the counters always accumulate. A panic enable turns any uncorrectable report into a sticky halt indication, and that report is then left out of the uncorrectable counters. Every statistic is read through a registered read port that has a single cycle of latency.

Top module: `mes_collector`

## Requirements
- R1: Every accepted correctable report adds one to the correctable total (address 0). Every accepted uncorrectable report adds one to the uncorrectable total (address 1). `ev_uncorr` = 1 marks an uncorrectable report.
- R2: A report with `ev_located` = 0 adds one to the matching no-location count (address 2 correctable, address 3 uncorrectable). It touches no row or channel count.
- R3: A report with `ev_located` = 1 adds one to the matching count of row `ev_row` and to the matching count of channel `ev_chan` in that row. Other rows and channels keep their values.
- R4: After power-on reset, every counter and the seconds timer read zero. A cycle with `clr_stats` high zeroes all of them again, and the timer then restarts counting from zero.
- R5: The seconds counter (address 4) advances by one every CLK_HZ cycles after a clear. A read whose address is applied j cycles after the clear edge returns floor((j-1)/CLK_HZ).
- R6: `log_valid` pulses one cycle after an accepted report when the log enable for that report's severity is high (`log_ce_en` for correctable, `log_ue_en` for uncorrectable). The pulse carries the report's severity, location flag, row and channel. The enables have no effect on any counter.
- R7: While `panic_ue_en` is high, an accepted uncorrectable report sets `halt` one cycle later, and `halt` then stays high until power-on reset. That report changes no uncorrectable counter. Correctable reports are still counted.
- R8: A counter at its maximum value, 2^CNT_W-1, stays there on further reports and does not wrap.
- R9: A report in the same cycle as `clr_stats` is dropped. All counters read zero afterwards, and no log pulse, alarm or halt results from it.
- R10: `rd_data` returns the register at `rd_addr` one cycle later. The address is {region, slot}, with a slot width of 3 bits by default. Region 0 holds slots 0 to 4 as listed above. Region r+1 holds row r: slot 0 is the correctable count, slot 1 the uncorrectable count, slot 2+2c the channel c correctable count, and slot 3+2c the channel c uncorrectable count. Unused slots read zero.
- R11: `ue_alarm` pulses for one cycle, one cycle after each accepted uncorrectable report, whether or not panic is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Error report pulse |
| ev_uncorr | input | 1 | 1 = uncorrectable, 0 = correctable |
| ev_located | input | 1 | 1 = row and channel are valid |
| ev_row | input | ROW_W | Row index of the report |
| ev_chan | input | CH_W | Channel index of the report |
| clr_stats | input | 1 | Zero all counters and restart the timer |
| log_ce_en | input | 1 | Enable log records for correctable reports |
| log_ue_en | input | 1 | Enable log records for uncorrectable reports |
| panic_ue_en | input | 1 | Halt on uncorrectable reports and skip their counting |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | DATA_W | Registered read data |
| log_valid | output | 1 | Log record valid |
| log_uncorr | output | 1 | Severity of the logged report |
| log_located | output | 1 | Location flag of the logged report |
| log_row | output | ROW_W | Row of the logged report |
| log_chan | output | CH_W | Channel of the logged report |
| ue_alarm | output | 1 | One-cycle pulse per uncorrectable report |
| halt | output | 1 | Sticky halt after a panic-mode uncorrectable report |

## Verification
The assertions take for granted that a located report always names a row below ROWS and a channel below CHANS. They also assume the clear command and the enables are ordinary levels sampled at the clock. The random stimulus draws row and channel indices modulo the configured counts, so it never produces an out-of-range location. The bench narrows counter width and the tick divisor so that saturation and several second boundaries are reached within a short run.

// File: rtl/mes_pkg.sv
package mes_pkg;
  // Slot numbers inside the controller-wide region (region 0).
  typedef enum logic [2:0] {
    SLOT_TOT_CE = 3'd0,
    SLOT_TOT_UE = 3'd1,
    SLOT_NI_CE  = 3'd2,
    SLOT_NI_UE  = 3'd3,
    SLOT_SECS   = 3'd4
  } glob_slot_e;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/mes_sat_cnt.sv
module mes_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] MAXV = '1;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc && cnt != MAXV) cnt <= cnt + 1'b1;
  end

  // R8: a full counter never wraps
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    (!clr && cnt == MAXV) |=> cnt == MAXV);
  // R1: at most one step per cycle
  assert_single_step_R1: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));
  // R4: clear zeroes the count
  assert_clear_zero_R4: assert property (@(posedge clk) disable iff (rst)
    clr |=> cnt == '0);
endmodule

// File: rtl/mes_sec_timer.sv
module mes_sec_timer #(
  parameter int CLK_HZ = 50_000_000,
  parameter int SEC_W  = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  output logic [SEC_W-1:0] secs
);
  localparam int PRE_W = (CLK_HZ > 1) ? $clog2(CLK_HZ) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_HZ - 1);

  logic [PRE_W-1:0] pre;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pre  <= '0;
      secs <= '0;
    end else if (pre == PRE_LAST) begin
      pre  <= '0;
      secs <= secs + 1'b1;
    end else begin
      pre <= pre + 1'b1;
    end
  end

  // R5: seconds only ever advance by one
  assert_sec_step_R5: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (secs == $past(secs) || secs == $past(secs) + 1'b1));
  // R5: prescaler stays inside its period
  assert_pre_range_R5: assert property (@(posedge clk) disable iff (rst)
    pre <= PRE_LAST);
  // R4: clear restarts the timer
  assert_sec_clear_R4: assert property (@(posedge clk) disable iff (rst)
    clr |=> secs == '0);
endmodule

// File: rtl/mes_event_gate.sv
module mes_event_gate #(
  parameter int ROWS  = 8,
  parameter int CHANS = 2,
  parameter int ROW_W = 3,
  parameter int CH_W  = 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ev_valid,
  input  logic                  ev_uncorr,
  input  logic                  ev_located,
  input  logic [ROW_W-1:0]      ev_row,
  input  logic [CH_W-1:0]       ev_chan,
  input  logic                  clr_stats,
  input  logic                  log_ce_en,
  input  logic                  log_ue_en,
  input  logic                  panic_ue_en,
  output logic                  inc_tot_ce,
  output logic                  inc_tot_ue,
  output logic                  inc_ni_ce,
  output logic                  inc_ni_ue,
  output logic [ROWS-1:0]       row_ce_hit,
  output logic [ROWS-1:0]       row_ue_hit,
  output logic [ROWS*CHANS-1:0] cell_ce_hit,
  output logic [ROWS*CHANS-1:0] cell_ue_hit,
  output logic                  log_valid,
  output logic                  log_uncorr,
  output logic                  log_located,
  output logic [ROW_W-1:0]      log_row,
  output logic [CH_W-1:0]       log_chan,
  output logic                  ue_alarm,
  output logic                  halt
);
  logic acc, ce, ue, ue_cnt;

  always_comb begin
    acc        = ev_valid && !clr_stats;
    ce         = acc && !ev_uncorr;
    ue         = acc && ev_uncorr;
    ue_cnt     = ue && !panic_ue_en;
    inc_tot_ce = ce;
    inc_tot_ue = ue_cnt;
    inc_ni_ce  = ce && !ev_located;
    inc_ni_ue  = ue_cnt && !ev_located;
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic row_sel;
    assign row_sel       = ev_located && (ev_row == ROW_W'(r));
    assign row_ce_hit[r] = ce && row_sel;
    assign row_ue_hit[r] = ue_cnt && row_sel;
    for (genvar c = 0; c < CHANS; c++) begin : g_ch
      assign cell_ce_hit[r*CHANS+c] = row_ce_hit[r] && (ev_chan == CH_W'(c));
      assign cell_ue_hit[r*CHANS+c] = row_ue_hit[r] && (ev_chan == CH_W'(c));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      log_valid   <= 1'b0;
      log_uncorr  <= 1'b0;
      log_located <= 1'b0;
      log_row     <= '0;
      log_chan    <= '0;
      ue_alarm    <= 1'b0;
      halt        <= 1'b0;
    end else begin
      log_valid <= (ce && log_ce_en) || (ue && log_ue_en);
      if (acc) begin
        log_uncorr  <= ev_uncorr;
        log_located <= ev_located;
        log_row     <= ev_row;
        log_chan    <= ev_chan;
      end
      ue_alarm <= ue;
      if (ue && panic_ue_en) halt <= 1'b1;
    end
  end

  // R3: input assumption on located reports
  assert_loc_range_R3: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && ev_located) |-> (int'(ev_row) < ROWS && int'(ev_chan) < CHANS));
  // R7: halt is sticky
  assert_halt_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    halt |=> halt);
  // R7: panic-mode uncorrectable report raises halt
  assert_halt_on_panic_R7: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && ev_uncorr && panic_ue_en && !clr_stats) |=> halt);
  // R6: a log record always follows a report
  assert_log_cause_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(log_valid) |-> $past(ev_valid));
  // R9: a report coinciding with a clear leaves no trace
  assert_clear_drop_R9: assert property (@(posedge clk) disable iff (rst)
    clr_stats |=> (!log_valid && !ue_alarm));
  // R11: the alarm is caused by an uncorrectable report
  assert_alarm_cause_R11: assert property (@(posedge clk) disable iff (rst)
    ue_alarm |-> ($past(ev_valid) && $past(ev_uncorr)));
endmodule

// File: rtl/mes_collector.sv
module mes_collector
  import mes_pkg::*;
#(
  parameter int  CNT_W  = 16,
  parameter int  ROWS   = 8,
  parameter int  CHANS  = 2,
  parameter int  CLK_HZ = 50_000_000,
  parameter int  SEC_W  = 32,
  localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CH_W   = (CHANS > 1) ? $clog2(CHANS) : 1,
  localparam int SLOT_W = max_int($clog2(2 * CHANS + 2), 3),
  localparam int RG_W   = $clog2(ROWS + 1),
  localparam int ADDR_W = RG_W + SLOT_W,
  localparam int DATA_W = max_int(SEC_W, CNT_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_valid,
  input  logic              ev_uncorr,
  input  logic              ev_located,
  input  logic [ROW_W-1:0]  ev_row,
  input  logic [CH_W-1:0]   ev_chan,
  input  logic              clr_stats,
  input  logic              log_ce_en,
  input  logic              log_ue_en,
  input  logic              panic_ue_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              log_valid,
  output logic              log_uncorr,
  output logic              log_located,
  output logic [ROW_W-1:0]  log_row,
  output logic [CH_W-1:0]   log_chan,
  output logic              ue_alarm,
  output logic              halt
);
  localparam int NCELL = ROWS * CHANS;

  logic                  inc_tot_ce, inc_tot_ue, inc_ni_ce, inc_ni_ue;
  logic [ROWS-1:0]       row_ce_hit, row_ue_hit;
  logic [NCELL-1:0]      cell_ce_hit, cell_ue_hit;
  logic [CNT_W-1:0]      tot_ce, tot_ue, ni_ce, ni_ue;
  logic [CNT_W-1:0]      row_ce_cnt  [ROWS];
  logic [CNT_W-1:0]      row_ue_cnt  [ROWS];
  logic [CNT_W-1:0]      cell_ce_cnt [NCELL];
  logic [CNT_W-1:0]      cell_ue_cnt [NCELL];
  logic [SEC_W-1:0]      secs;
  logic [DATA_W-1:0]     rd_next;

  mes_event_gate #(.ROWS(ROWS), .CHANS(CHANS), .ROW_W(ROW_W), .CH_W(CH_W)) u_gate (
    .clk(clk), .rst(rst),
    .ev_valid(ev_valid), .ev_uncorr(ev_uncorr), .ev_located(ev_located),
    .ev_row(ev_row), .ev_chan(ev_chan), .clr_stats(clr_stats),
    .log_ce_en(log_ce_en), .log_ue_en(log_ue_en), .panic_ue_en(panic_ue_en),
    .inc_tot_ce(inc_tot_ce), .inc_tot_ue(inc_tot_ue),
    .inc_ni_ce(inc_ni_ce), .inc_ni_ue(inc_ni_ue),
    .row_ce_hit(row_ce_hit), .row_ue_hit(row_ue_hit),
    .cell_ce_hit(cell_ce_hit), .cell_ue_hit(cell_ue_hit),
    .log_valid(log_valid), .log_uncorr(log_uncorr), .log_located(log_located),
    .log_row(log_row), .log_chan(log_chan), .ue_alarm(ue_alarm), .halt(halt)
  );

  mes_sec_timer #(.CLK_HZ(CLK_HZ), .SEC_W(SEC_W)) u_timer (
    .clk(clk), .rst(rst), .clr(clr_stats), .secs(secs)
  );

  mes_sat_cnt #(.W(CNT_W)) u_tot_ce (.clk(clk), .rst(rst), .clr(clr_stats), .inc(inc_tot_ce), .cnt(tot_ce));
  mes_sat_cnt #(.W(CNT_W)) u_tot_ue (.clk(clk), .rst(rst), .clr(clr_stats), .inc(inc_tot_ue), .cnt(tot_ue));
  mes_sat_cnt #(.W(CNT_W)) u_ni_ce  (.clk(clk), .rst(rst), .clr(clr_stats), .inc(inc_ni_ce),  .cnt(ni_ce));
  mes_sat_cnt #(.W(CNT_W)) u_ni_ue  (.clk(clk), .rst(rst), .clr(clr_stats), .inc(inc_ni_ue),  .cnt(ni_ue));

  for (genvar r = 0; r < ROWS; r++) begin : g_rowcnt
    mes_sat_cnt #(.W(CNT_W)) u_rce (.clk(clk), .rst(rst), .clr(clr_stats),
      .inc(row_ce_hit[r]), .cnt(row_ce_cnt[r]));
    mes_sat_cnt #(.W(CNT_W)) u_rue (.clk(clk), .rst(rst), .clr(clr_stats),
      .inc(row_ue_hit[r]), .cnt(row_ue_cnt[r]));
  end

  for (genvar k = 0; k < NCELL; k++) begin : g_cellcnt
    mes_sat_cnt #(.W(CNT_W)) u_cce (.clk(clk), .rst(rst), .clr(clr_stats),
      .inc(cell_ce_hit[k]), .cnt(cell_ce_cnt[k]));
    mes_sat_cnt #(.W(CNT_W)) u_cue (.clk(clk), .rst(rst), .clr(clr_stats),
      .inc(cell_ue_hit[k]), .cnt(cell_ue_cnt[k]));
  end

  // Read decode: region selects global block or a row, slot selects the counter.
  always_comb begin
    logic [RG_W-1:0]   region;
    logic [SLOT_W-1:0] slot;
    region  = rd_addr[ADDR_W-1:SLOT_W];
    slot    = rd_addr[SLOT_W-1:0];
    rd_next = '0;
    if (region == '0) begin
      if      (slot == SLOT_W'(SLOT_TOT_CE)) rd_next = DATA_W'(tot_ce);
      else if (slot == SLOT_W'(SLOT_TOT_UE)) rd_next = DATA_W'(tot_ue);
      else if (slot == SLOT_W'(SLOT_NI_CE))  rd_next = DATA_W'(ni_ce);
      else if (slot == SLOT_W'(SLOT_NI_UE))  rd_next = DATA_W'(ni_ue);
      else if (slot == SLOT_W'(SLOT_SECS))   rd_next = DATA_W'(secs);
    end
    for (int r = 0; r < ROWS; r++) begin
      if (region == RG_W'(r + 1)) begin
        if (slot == SLOT_W'(0)) rd_next = DATA_W'(row_ce_cnt[r]);
        if (slot == SLOT_W'(1)) rd_next = DATA_W'(row_ue_cnt[r]);
        for (int c = 0; c < CHANS; c++) begin
          if (slot == SLOT_W'(2 + 2 * c)) rd_next = DATA_W'(cell_ce_cnt[r*CHANS+c]);
          if (slot == SLOT_W'(3 + 2 * c)) rd_next = DATA_W'(cell_ue_cnt[r*CHANS+c]);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end

  // R1: the correctable total moves with every correctable report
  assert_total_tracks_R1: assert property (@(posedge clk) disable iff (rst)
    (inc_tot_ce && !clr_stats && tot_ce != '1) |=> tot_ce != $past(tot_ce));
  // R2: an unlocated report touches no row counter
  assert_unlocated_rows_R2: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && !ev_located) |-> (row_ce_hit == '0 && row_ue_hit == '0));
  // R3: at most one row and one cell hit per report
  assert_one_row_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({row_ce_hit, row_ue_hit}) && $onehot0({cell_ce_hit, cell_ue_hit}));
  // R7: panic mode freezes the uncorrectable total
  assert_panic_freeze_R7: assert property (@(posedge clk) disable iff (rst)
    (panic_ue_en && !clr_stats) |=> $stable(tot_ue));
  // R9: a clear leaves the totals at zero despite a coincident report
  assert_clear_wins_R9: assert property (@(posedge clk) disable iff (rst)
    clr_stats |=> (tot_ce == '0 && tot_ue == '0));
endmodule

// File: tb/test_mes_collector.sv
module test_mes_collector;
  localparam int CNT_W  = 6;
  localparam int ROWS   = 8;
  localparam int CHANS  = 2;
  localparam int CLK_HZ = 20;
  localparam int SLOT_W = 3;
  localparam int MAXC   = (1 << CNT_W) - 1;

  logic        clk = 1'b0;
  logic        rst;
  logic        ev_valid, ev_uncorr, ev_located;
  logic [2:0]  ev_row;
  logic [0:0]  ev_chan;
  logic        clr_stats, log_ce_en, log_ue_en, panic_ue_en;
  logic [6:0]  rd_addr;
  logic [31:0] rd_data;
  logic        log_valid, log_uncorr, log_located;
  logic [2:0]  log_row;
  logic [0:0]  log_chan;
  logic        ue_alarm, halt;

  int n_chk = 0;
  int n_bad = 0;

  int m_tot  [2];
  int m_ni   [2];
  int m_row  [ROWS][2];
  int m_cell [ROWS][CHANS][2];
  bit m_halt;

  always #10 clk = ~clk;

  mes_collector #(.CNT_W(CNT_W), .ROWS(ROWS), .CHANS(CHANS), .CLK_HZ(CLK_HZ)) i_mes_collector (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_uncorr(ev_uncorr),
    .ev_located(ev_located), .ev_row(ev_row), .ev_chan(ev_chan),
    .clr_stats(clr_stats), .log_ce_en(log_ce_en), .log_ue_en(log_ue_en),
    .panic_ue_en(panic_ue_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .log_valid(log_valid), .log_uncorr(log_uncorr), .log_located(log_located),
    .log_row(log_row), .log_chan(log_chan), .ue_alarm(ue_alarm), .halt(halt)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int sat1(input int v);
    return (v >= MAXC) ? MAXC : v + 1;
  endfunction

  function automatic void model_clear();
    for (int t = 0; t < 2; t++) begin
      m_tot[t] = 0;
      m_ni[t]  = 0;
      for (int r = 0; r < ROWS; r++) begin
        m_row[r][t] = 0;
        for (int c = 0; c < CHANS; c++) m_cell[r][c][t] = 0;
      end
    end
  endfunction

  function automatic int exp_at(input int region, input int slot);
    if (region == 0) begin
      case (slot)
        0: return m_tot[0];
        1: return m_tot[1];
        2: return m_ni[0];
        3: return m_ni[1];
        default: return 0;
      endcase
    end
    if (slot < 2) return m_row[region-1][slot];
    if (slot < 2 + 2 * CHANS) return m_cell[region-1][(slot-2)/2][slot%2];
    return 0;
  endfunction

  task automatic rd(input int region, input int slot, output int val);
    rd_addr = 7'((region << SLOT_W) | slot);
    @(posedge clk);
    @(negedge clk);
    val = int'(rd_data);
  endtask

  // R10 map walk; seconds slot skipped, it moves on its own
  task automatic check_all(input string tag);
    int v;
    for (int g = 0; g <= ROWS; g++) begin
      for (int s = 0; s < 8; s++) begin
        if (!(g == 0 && s == 4)) begin
          rd(g, s, v);
          chk(v == exp_at(g, s), $sformatf("%s R10 region%0d slot%0d", tag, g, s), v, exp_at(g, s));
        end
      end
    end
  endtask

  task automatic send(input bit v, input bit ue, input bit loc, input int row, input int ch, input bit clr);
    bit acc, exp_log, exp_alarm;
    ev_valid   = v;
    ev_uncorr  = ue;
    ev_located = loc;
    ev_row     = 3'(row);
    ev_chan    = 1'(ch);
    clr_stats  = clr;
    acc        = v && !clr;
    exp_log    = acc && (ue ? log_ue_en : log_ce_en);
    exp_alarm  = acc && ue;
    if (clr) model_clear();
    if (acc) begin
      if (ue && panic_ue_en) m_halt = 1'b1;
      else begin
        m_tot[ue] = sat1(m_tot[ue]);
        if (!loc) m_ni[ue] = sat1(m_ni[ue]);
        else begin
          m_row[row][ue]     = sat1(m_row[row][ue]);
          m_cell[row][ch][ue] = sat1(m_cell[row][ch][ue]);
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
    ev_valid  = 1'b0;
    clr_stats = 1'b0;
    chk(log_valid == exp_log, "R6 log_valid", log_valid, exp_log);
    if (exp_log) begin
      chk(log_uncorr == ue && log_located == loc && int'(log_row) == row && int'(log_chan) == ch,
          "R6 log fields", {log_uncorr, log_located, log_row, log_chan},
          {ue, loc, 3'(row), 1'(ch)});
    end
    chk(ue_alarm == exp_alarm, (clr ? "R9 alarm" : "R11 ue_alarm"), ue_alarm, exp_alarm);
    chk(halt == m_halt, "R7 halt", halt, m_halt);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int v;
    void'($urandom(32'd2718));
    rst = 1'b1; ev_valid = 0; ev_uncorr = 0; ev_located = 0; ev_row = 0; ev_chan = 0;
    clr_stats = 0; log_ce_en = 0; log_ue_en = 0; panic_ue_en = 0; rd_addr = 0;
    m_halt = 0;
    model_clear();
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R4 reset state
    chk(!log_valid && !ue_alarm && !halt, "R4 outputs after reset", {log_valid, ue_alarm, halt}, 0);
    check_all("R4 reset");

    // R1 R3 located correctable, R2 unlocated uncorrectable
    send(1, 0, 1, 3, 1, 0);
    send(1, 1, 0, 0, 0, 0);
    send(1, 1, 1, 7, 0, 0);
    check_all("R1 R2 R3 directed");

    // R6 log gating, counters still counting
    log_ce_en = 1;
    send(1, 0, 1, 5, 0, 0);
    send(1, 1, 1, 5, 1, 0);
    log_ce_en = 0; log_ue_en = 1;
    send(1, 1, 1, 2, 1, 0);
    send(1, 0, 0, 0, 0, 0);
    log_ue_en = 0;
    check_all("R6 counts with logging");

    // R4 R5 clear and seconds timing
    clr_stats = 1;
    rd_addr = 7'd4;
    model_clear();
    @(posedge clk);
    @(negedge clk);
    clr_stats = 0;
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk(rd_data == 0, "R5 secs before first tick", rd_data, 0);
    @(posedge clk);
    @(negedge clk);
    chk(rd_data == 1, "R5 secs at first tick", rd_data, 1);
    repeat (19) @(posedge clk);
    @(negedge clk);
    chk(rd_data == 1, "R5 secs before second tick", rd_data, 1);
    @(posedge clk);
    @(negedge clk);
    chk(rd_data == 2, "R5 secs at second tick", rd_data, 2);
    check_all("R4 after clear");

    // R9 event coincident with clear
    send(1, 0, 1, 1, 1, 0);
    send(1, 1, 1, 1, 1, 1);
    check_all("R9 clear drops event");

    // R8 saturation
    for (int i = 0; i < MAXC + 6; i++) send(1, 0, 1, 0, 0, 0);
    check_all("R8 saturation");
    send(1, 0, 0, 0, 0, 1);

    // random mix, R1 R2 R3 R6 R9 R11
    for (int i = 0; i < 600; i++) begin
      log_ce_en = 1'($urandom % 2);
      log_ue_en = 1'($urandom % 2);
      send(($urandom % 4) != 0, 1'($urandom % 2), ($urandom % 3) != 0,
           int'($urandom % ROWS), int'($urandom % CHANS), ($urandom % 40) == 0);
      if (i % 150 == 149) check_all("R1 R3 random");
    end
    check_all("R2 R3 random end");

    // R7 panic mode
    panic_ue_en = 1; log_ue_en = 1;
    send(1, 1, 1, 4, 1, 0);
    send(1, 0, 1, 4, 1, 0);
    send(1, 1, 0, 0, 0, 0);
    panic_ue_en = 0;
    send(0, 0, 0, 0, 0, 0);
    chk(halt == 1, "R7 halt sticky", halt, 1);
    check_all("R7 panic counts");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule